// File: doc/BRIEF.md
# DMA Translation Fault Capture Unit

This block sits beside an address translation pipeline and keeps a record of the first DMA access that failed to translate. Each fault report from the pipeline carries its class (a segment miss or a page miss), the page address that was being accessed, whether the access was a read or a write, and the identifier of the requesting device. When the report's class is enabled, the block packs these fields into a 64-bit status word, marks it valid and raises a level interrupt.

The record is sticky and holds one entry. Later faults are dropped until software acknowledges the first one by writing the status word back with its top bit cleared. A second register holds one enable bit per fault class. A report whose class is disabled leaves no trace. Both registers sit behind a small register port with a one-bit select, a write strobe and combinational read data.

Top module: `flt_cap_unit`

## Requirements
- R1: After reset the status word and the enable register both read as zero and `irq` is low.
- R2: An enabled fault arriving while no record is held is captured at the next clock edge. Status bit 63 is set to 1. Bits 62:61 hold 11 for a segment fault or 01 for a page fault. Bits 34:12 hold the page address, bit 11 holds 1 for a read and 0 for a write, and bits 10:0 hold the device identifier. Bits 60:35 read as zero.
- R3: The enable register is selected with `reg_sel`=1 (status uses `reg_sel`=0). Bit 62 enables segment faults and bit 61 enables page faults. A write stores those two bits only, and every other bit reads back as zero.
- R4: A fault whose class is disabled changes neither the status word nor `irq`.
- R5: While a valid record is held, further faults are ignored and the first record stays unchanged.
- R6: A status write with bit 63 equal to 0 clears the whole record to zero. A status write with bit 63 equal to 1 has no effect.
- R7: `irq` is high exactly while a valid record is held and its class is enabled in the enable register. It follows changes to the enable register one edge after they are written.
- R8: When a clearing status write and an enabled fault occur in the same cycle, the new fault is captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flt_valid | input | 1 | A fault report is present this cycle |
| flt_is_seg | input | 1 | 1 = segment fault, 0 = page fault |
| flt_page | input | PAGE_W (23) | Faulting page address |
| flt_read | input | 1 | 1 = read access, 0 = write access |
| flt_dev | input | DEV_W (11) | Requesting device identifier |
| reg_sel | input | 1 | 0 = status word, 1 = enable register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq | output | 1 | Level interrupt |

## Verification
The status word and `irq` change on the first clock edge after a fault report or a register write. Read data follows `reg_sel` without a clock. Each bench operation therefore holds its stimulus across exactly one rising edge and releases it at the next falling edge. The bench then sets the select, lets it settle for a nanosecond and hands the expected word and interrupt level to the scoreboard. Because of this, every comparison lands in the cycle right after the edge that should have produced the result, before any further stimulus.

// File: rtl/flt_cap_pkg.sv
package flt_cap_pkg;

  localparam int WORD_W    = 64;
  localparam int VALID_BIT = 63;
  localparam int CLS_HI    = 62;
  localparam int CLS_LO    = 61;
  localparam int EN_SEG_BIT  = 62;
  localparam int EN_PAGE_BIT = 61;
  localparam int NUM_CLS   = 2;

  localparam logic [1:0] CODE_PAGE = 2'b01;
  localparam logic [1:0] CODE_SEG  = 2'b11;

  // index 0 = page class, index 1 = segment class
  localparam logic [1:0] CLS_CODE [NUM_CLS] = '{CODE_PAGE, CODE_SEG};

  function automatic logic [1:0] class_code(input logic is_seg);
    return is_seg ? CODE_SEG : CODE_PAGE;
  endfunction

endpackage

// File: rtl/flt_cap_gate.sv
module flt_cap_gate
  import flt_cap_pkg::*;
(
  input  logic       flt_valid,
  input  logic       flt_is_seg,
  input  logic       en_seg,
  input  logic       en_page,
  output logic       accept,
  output logic [1:0] cls_code
);

  logic class_enabled;

  assign class_enabled = flt_is_seg ? en_seg : en_page;
  assign accept        = flt_valid & class_enabled;
  assign cls_code      = class_code(flt_is_seg);

endmodule

// File: rtl/flt_cap_mask.sv
module flt_cap_mask
  import flt_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_seg,
  input  logic              wr_page,
  output logic              en_seg,
  output logic              en_page,
  output logic [WORD_W-1:0] mask_word
);

  logic [1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 2'b00;
    else if (wr_en) en_q <= {wr_seg, wr_page};
  end

  assign en_seg  = en_q[1];
  assign en_page = en_q[0];

  always_comb begin
    mask_word = '0;
    mask_word[EN_SEG_BIT]  = en_q[1];
    mask_word[EN_PAGE_BIT] = en_q[0];
  end

endmodule

// File: rtl/flt_cap_status.sv
module flt_cap_status
  import flt_cap_pkg::*;
#(
  parameter int PAGE_W = 23,
  parameter int DEV_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [1:0]        cls_code,
  input  logic [PAGE_W-1:0] page,
  input  logic              rd,
  input  logic [DEV_W-1:0]  dev,
  input  logic              sw_wr,
  input  logic              sw_valid_bit,
  output logic [WORD_W-1:0] status_q,
  output logic              load_evt,
  output logic              clr_evt
);

  localparam int RW_BIT  = DEV_W;
  localparam int PG_LO   = DEV_W + 1;
  localparam int PG_HI   = DEV_W + PAGE_W;

  function automatic logic [WORD_W-1:0] build_record(
    input logic [1:0]        c,
    input logic [PAGE_W-1:0] p,
    input logic              r,
    input logic [DEV_W-1:0]  d
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[VALID_BIT]     = 1'b1;
    w[CLS_HI:CLS_LO] = c;
    w[PG_HI:PG_LO]   = p;
    w[RW_BIT]        = r;
    w[DEV_W-1:0]     = d;
    return w;
  endfunction

  logic held;

  assign held     = status_q[VALID_BIT];
  assign clr_evt  = sw_wr & ~sw_valid_bit;
  assign load_evt = accept & (~held | clr_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= '0;
    else if (load_evt) status_q <= build_record(cls_code, page, rd, dev);
    else if (clr_evt)  status_q <= '0;
  end

  assert_first_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !clr_evt) |=> $stable(status_q))
    else $error("held record changed without a clear");

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !accept) |=> (status_q == '0))
    else $error("clear did not empty the record");

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clr_evt) |=> status_q[VALID_BIT])
    else $error("fault coinciding with clear was lost");

endmodule

// File: rtl/flt_cap_unit.sv
module flt_cap_unit
  import flt_cap_pkg::*;
#(
  parameter int PAGE_W = 23,
  parameter int DEV_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt_valid,
  input  logic              flt_is_seg,
  input  logic [PAGE_W-1:0] flt_page,
  input  logic              flt_read,
  input  logic [DEV_W-1:0]  flt_dev,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              irq
);

  logic              en_seg, en_page;
  logic              accept;
  logic [1:0]        cls_code;
  logic [WORD_W-1:0] status_q, mask_word;
  logic              load_evt, clr_evt;
  logic              status_valid;
  logic [1:0]        status_cls;
  logic [NUM_CLS-1:0] en_vec, cls_pend;
  logic              unused_wdata;

  assign unused_wdata = ^{reg_wdata[60:0]};

  flt_cap_gate u_gate (
    .flt_valid (flt_valid),
    .flt_is_seg(flt_is_seg),
    .en_seg    (en_seg),
    .en_page   (en_page),
    .accept    (accept),
    .cls_code  (cls_code)
  );

  flt_cap_mask u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr & reg_sel),
    .wr_seg   (reg_wdata[EN_SEG_BIT]),
    .wr_page  (reg_wdata[EN_PAGE_BIT]),
    .en_seg   (en_seg),
    .en_page  (en_page),
    .mask_word(mask_word)
  );

  flt_cap_status #(.PAGE_W(PAGE_W), .DEV_W(DEV_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cls_code    (cls_code),
    .page        (flt_page),
    .rd          (flt_read),
    .dev         (flt_dev),
    .sw_wr       (reg_wr & ~reg_sel),
    .sw_valid_bit(reg_wdata[VALID_BIT]),
    .status_q    (status_q),
    .load_evt    (load_evt),
    .clr_evt     (clr_evt)
  );

  assign status_valid = status_q[VALID_BIT];
  assign status_cls   = status_q[CLS_HI:CLS_LO];
  assign en_vec       = {en_seg, en_page};

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_pend
    assign cls_pend[g] = status_valid & (status_cls == CLS_CODE[g]) & en_vec[g];
  end

  assign irq       = |cls_pend;
  assign reg_rdata = reg_sel ? mask_word : status_q;

  assert_irq_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_valid)
    else $error("interrupt without a held record");

  assert_class_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_valid |-> (status_cls == CODE_SEG || status_cls == CODE_PAGE))
    else $error("illegal class code captured");

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !status_valid && !clr_evt &&
     !(flt_is_seg ? reg_rdata_en_seg() : reg_rdata_en_page())) |=> !status_valid)
    else $error("disabled fault class left state");

  function automatic logic reg_rdata_en_seg();
    return mask_word[EN_SEG_BIT];
  endfunction

  function automatic logic reg_rdata_en_page();
    return mask_word[EN_PAGE_BIT];
  endfunction

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (status_valid && irq))
    else $error("captured fault did not raise the interrupt");

endmodule

// File: tb/flt_cap_unit_tb.sv
module flt_cap_unit_tb;

  localparam int PAGE_W = 23;
  localparam int DEV_W  = 11;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flt_valid = 1'b0;
  logic              flt_is_seg = 1'b0;
  logic [PAGE_W-1:0] flt_page = '0;
  logic              flt_read = 1'b0;
  logic [DEV_W-1:0]  flt_dev = '0;
  logic              reg_sel = 1'b0;
  logic              reg_wr = 1'b0;
  logic [63:0]       reg_wdata = '0;
  logic [63:0]       reg_rdata;
  logic              irq;

  always #2 clk = ~clk;

  flt_cap_unit #(.PAGE_W(PAGE_W), .DEV_W(DEV_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .flt_valid(flt_valid), .flt_is_seg(flt_is_seg), .flt_page(flt_page),
    .flt_read(flt_read), .flt_dev(flt_dev),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct {
    logic [63:0] word;
    logic        irq_lvl;
    string       tag;
  } exp_t;

  exp_t q[$];
  event ev_chk;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 0;

  localparam logic [63:0] M_BOTH = 64'h6000_0000_0000_0000;
  localparam logic [63:0] M_SEG  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] M_PAGE = 64'h2000_0000_0000_0000;

  function automatic logic [63:0] rec(input logic seg, input logic [22:0] pg,
                                      input logic rd, input logic [10:0] dv);
    logic [63:0] c;
    c = seg ? 64'd3 : 64'd1;
    return (64'd1 << 63) | (c << 61) | (64'(pg) << 12) | (64'(rd) << 11) | 64'(dv);
  endfunction

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_vec++;
        if (reg_rdata !== e.word || irq !== e.irq_lvl) begin
          n_bad++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   e.tag, reg_rdata, irq, e.word, e.irq_lvl);
        end
      end
    end
  end

  // one clock of stimulus, released at the following falling edge
  task automatic step(input logic f, input logic seg, input logic [22:0] pg,
                      input logic rd, input logic [10:0] dv,
                      input logic w, input logic sel, input logic [63:0] d);
    @(negedge clk);
    flt_valid = f; flt_is_seg = seg; flt_page = pg; flt_read = rd; flt_dev = dv;
    reg_wr = w; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    flt_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic fault(input logic seg, input logic [22:0] pg,
                       input logic rd, input logic [10:0] dv);
    step(1'b1, seg, pg, rd, dv, 1'b0, 1'b0, 64'd0);
  endtask

  task automatic wr(input logic sel, input logic [63:0] d);
    step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, sel, d);
  endtask

  task automatic expect_item(input logic sel, input logic [63:0] w,
                             input logic i, input string tag);
    exp_t e;
    reg_sel = sel;
    #1;
    e.word = w; e.irq_lvl = i; e.tag = tag;
    q.push_back(e);
    ->ev_chk;
    #0;
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] r1, r2;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_item(1'b0, 64'd0, 1'b0, "R1 status after reset");
    expect_item(1'b1, 64'd0, 1'b0, "R1 mask after reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R3 only enable bits stick
    wr(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_item(1'b1, M_BOTH, 1'b0, "R3 mask all-ones write");
    wr(1'b1, M_SEG);
    expect_item(1'b1, M_SEG, 1'b0, "R3 mask segment only");
    // R4 masked page fault
    fault(1'b0, 23'h12345, 1'b1, 11'h3);
    expect_item(1'b0, 64'd0, 1'b0, "R4 disabled page fault");
    // R2 / R7 capture segment read fault
    r1 = rec(1'b1, 23'h7FFFFF, 1'b1, 11'h7FF);
    fault(1'b1, 23'h7FFFFF, 1'b1, 11'h7FF);
    expect_item(1'b0, r1, 1'b1, "R2 segment fault captured");
    // R5 later fault dropped
    fault(1'b1, 23'h1, 1'b0, 11'h1);
    expect_item(1'b0, r1, 1'b1, "R5 second fault ignored");
    // R6 write with valid=1 has no effect
    wr(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    expect_item(1'b0, r1, 1'b1, "R6 write with valid set");
    // R7 irq follows mask
    wr(1'b1, M_PAGE);
    expect_item(1'b0, r1, 1'b0, "R7 class disabled after capture");
    wr(1'b1, M_BOTH);
    expect_item(1'b0, r1, 1'b1, "R7 class re-enabled");
    // R6 clear
    wr(1'b0, 64'h7FFF_FFFF_FFFF_FFFF);
    expect_item(1'b0, 64'd0, 1'b0, "R6 clear record");
    // R2 page write fault
    r2 = rec(1'b0, 23'h2AAAA5, 1'b0, 11'h155);
    fault(1'b0, 23'h2AAAA5, 1'b0, 11'h155);
    expect_item(1'b0, r2, 1'b1, "R2 page fault captured");
    // R8 clear and fault together
    r1 = rec(1'b1, 23'h0, 1'b0, 11'h0);
    step(1'b1, 1'b1, 23'h0, 1'b0, 11'h0, 1'b1, 1'b0, 64'd0);
    expect_item(1'b0, r1, 1'b1, "R8 fault with same-cycle clear");
    // R7 mask cleared drops irq
    wr(1'b1, 64'd0);
    expect_item(1'b0, r1, 1'b0, "R7 all classes disabled");
    wr(1'b0, 64'd0);
    // R4 both classes disabled
    fault(1'b1, 23'h55, 1'b1, 11'h2);
    expect_item(1'b0, 64'd0, 1'b0, "R4 disabled segment fault");
    expect_item(1'b1, 64'd0, 1'b0, "R3 mask readback zero");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule